// File: doc/BRIEF.md
# Serial Debug Port Transaction Sequencer

This block sits between an external debug tool and a processor core held in debug mode. The tool clocks frames into the port one bit at a time. Each frame opens with a start bit and carries a mode bit and a 32-bit payload. When a frame completes, the block hands the payload to the core through a one-cycle command pulse. While the frame is being clocked in, the block shifts a response out on the serial data-out line. The response is a 2-bit status code followed by 32 data bits. It carries data the core wrote during the previous exchange, a deferred error, or a null marker.

Between frames the data-out line acts as a ready flag: low when the core has no outstanding work. A tool may start a frame early, while ready is withheld. In that case the block keeps ready withheld until the frame and the core work it triggered have both finished. A frame that completes while the core is still busy is discarded and recorded as a sequence error. A core exception is also recorded. Each recorded error waits for the next start bit, and it is reported in that frame. The frame carrying an error report is itself never forwarded to the core. Data the core writes only reaches the response if the tool leaves enough idle clocks before the next start bit. Otherwise the data is dropped silently.

Top module: `dbgp_seq`

## Requirements
- R1: A frame begins when `bit_stb` samples `sdi`=1 with the port idle. It is followed by the mode bit, 32 payload bits (most significant first) and one turnaround bit whose value is ignored. On the strobe of the turnaround bit the port goes idle. In the next cycle a forwarded frame raises `cmd_valid` for exactly one cycle, with `cmd_mode` and `cmd_word` holding the mode bit and the payload.
- R2: Out of reset and between frames, `sdo` is 0 when no core operation is outstanding and 1 while one is. A forwarded frame starts an outstanding operation, and a `core_done` pulse ends it.
- R3: While a frame is being clocked in, `sdo` presents a 34-bit response, most significant bit first. The value in front of strobe k (k = 1..34 after the start strobe) is response bit 34-k. Bits 33:32 hold the status: 00 valid data, 01 sequence error, 10 core exception, 11 null. Bits 31:0 hold data, which is zero for any status other than valid.
- R4: A frame that completes while an operation is outstanding, with no `core_done` in that same cycle, is not forwarded and records a sequence error.
- R5: A `core_done` pulse with `core_exc` high records a core exception.
- R6: A recorded error is reported in the first frame whose start bit arrives on a later clock edge than the error, and is then cleared. An error arising after a start bit therefore waits for the frame after that one. A newer error replaces an unreported older one.
- R7: A frame whose response carries an error status is ignored: it is never forwarded and never raises a sequence error.
- R8: A frame started while ready is withheld keeps `sdo` at 1 after it ends, for as long as the outstanding operation (old or new) has not completed.
- R9: A `core_wr` pulse holds `core_wdata` for the next start bit. That frame returns the data with valid status only if the start edge comes at least 4 clock edges after the turnaround strobe of the previous frame. Otherwise the frame returns null status, the data is discarded, and no error is recorded.
- R10: A strobe with `sdi`=0 while idle starts nothing and leaves `sdo` at its ready value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_stb | input | 1 | One-cycle strobe: sample `sdi` as the next serial bit |
| sdi | input | 1 | Serial data from the debug tool |
| sdo | output | 1 | Serial response while a frame is active; ready flag (0 = ready) while idle |
| cmd_valid | output | 1 | One-cycle pulse: a received frame is handed to the core |
| cmd_mode | output | 1 | Mode bit of the forwarded frame |
| cmd_word | output | 32 | Payload of the forwarded frame |
| core_done | input | 1 | Core finished the work for the last forwarded frame |
| core_exc | input | 1 | Qualifies `core_done`: the work ended in an exception |
| core_wr | input | 1 | Core writes the port data register |
| core_wdata | input | 32 | Data written by the core |

## Verification
Core events are asynchronous to the tool's frame timing, so three pairs of events can land on the same clock edge. A core exception or a `core_done` can coincide with the turnaround strobe, which decides between forwarding and a sequence error. An exception or a core write can coincide with a start bit, which decides whether it goes into the current response or the next one. The bench provokes these by mixing core latencies of 1 to 3 cycles and 90 cycles with random idle gaps of 0 to 6 cycles, including early starts. It keeps a time-stamped record of every error and write edge, and from that record predicts each response, the forwarding decision and the ready level, giving the newer event precedence whenever two share an edge.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;
  typedef enum logic [1:0] {
    ST_VALID = 2'b00,
    ST_SEQ   = 2'b01,
    ST_EXC   = 2'b10,
    ST_NULL  = 2'b11
  } dp_stat_e;
endpackage

// File: rtl/dbgp_rx.sv
module dbgp_rx #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              sdi,
  output logic              active,
  output logic              start,
  output logic              done,
  output logic              frame_mode,
  output logic [DATA_W-1:0] frame_word
);
  // strobes after the start bit: mode, payload, turnaround
  localparam int SLOTS = DATA_W + 2;
  localparam int LAST  = SLOTS - 1;
  localparam int CW    = $clog2(SLOTS);

  logic              act_q, act_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [DATA_W:0]   sh_q, sh_d;

  assign start = !act_q && bit_stb && sdi;
  assign done  = act_q && bit_stb && (cnt_q == CW'(LAST));

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    sh_d  = sh_q;
    if (start) begin
      act_d = 1'b1;
      cnt_d = '0;
    end else if (act_q && bit_stb) begin
      cnt_d = cnt_q + CW'(1);
      if (cnt_q < CW'(LAST)) sh_d = {sh_q[DATA_W-1:0], sdi};
      if (done) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
    end
  end

  assign active     = act_q;
  assign frame_mode = sh_q[DATA_W];
  assign frame_word = sh_q[DATA_W-1:0];

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (cnt_q <= CW'(LAST)));  // R1
endmodule

// File: rtl/dbgp_tx.sv
module dbgp_tx #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W+1:0] load_frame,
  input  logic              shift,
  output logic              msb
);
  import dbgp_pkg::*;
  localparam int TOP = DATA_W + 1;

  logic [TOP:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load)       sh_d = load_frame;
    else if (shift) sh_d = {sh_q[TOP-1:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign msb = sh_q[TOP];

  AST_ERR_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (load_frame[TOP:TOP-1] != ST_VALID)) |=> (sh_q[DATA_W-1:0] == '0));  // R3
endmodule

// File: rtl/dbgp_ctl.sv
module dbgp_ctl #(
  parameter int DATA_W  = 32,
  parameter int GAP_MIN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              done,
  input  logic              core_done,
  input  logic              core_exc,
  input  logic              core_wr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic              fwd,
  output logic              busy,
  output logic              ign,
  output logic [DATA_W+1:0] load_frame
);
  import dbgp_pkg::*;
  localparam int GW = $clog2(GAP_MIN + 1);

  dp_stat_e          err_q, err_d;
  logic              busy_q, busy_d;
  logic              ign_q, ign_d;
  logic              dpend_q, dpend_d;
  logic [DATA_W-1:0] dhold_q, dhold_d;
  logic [GW-1:0]     gap_q, gap_d;
  logic              seq_err, exc_evt, gap_ok;

  assign seq_err = done && !ign_q && busy_q && !core_done;
  assign exc_evt = core_done && core_exc;
  assign fwd     = done && !ign_q && !seq_err;
  assign gap_ok  = (gap_q == GW'(GAP_MIN - 1));

  always_comb begin
    if (err_q != ST_NULL)      load_frame = {err_q, {DATA_W{1'b0}}};
    else if (dpend_q && gap_ok) load_frame = {ST_VALID, dhold_q};
    else                        load_frame = {ST_NULL, {DATA_W{1'b0}}};
  end

  always_comb begin
    err_d   = err_q;
    busy_d  = busy_q;
    ign_d   = ign_q;
    dpend_d = dpend_q;
    dhold_d = dhold_q;
    gap_d   = gap_q;
    if (start)   err_d = ST_NULL;
    if (seq_err) err_d = ST_SEQ;
    if (exc_evt) err_d = ST_EXC;
    if (start)   ign_d = (err_q != ST_NULL);
    if (core_done) busy_d = 1'b0;
    if (fwd)       busy_d = 1'b1;
    if (start)   dpend_d = 1'b0;
    if (core_wr) begin
      dpend_d = 1'b1;
      dhold_d = core_wdata;
    end
    if (done)         gap_d = '0;
    else if (!gap_ok) gap_d = gap_q + GW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= ST_NULL;
      busy_q  <= 1'b0;
      ign_q   <= 1'b0;
      dpend_q <= 1'b0;
      dhold_q <= '0;
      gap_q   <= GW'(GAP_MIN - 1);
    end else begin
      err_q   <= err_d;
      busy_q  <= busy_d;
      ign_q   <= ign_d;
      dpend_q <= dpend_d;
      dhold_q <= dhold_d;
      gap_q   <= gap_d;
    end
  end

  assign busy = busy_q;
  assign ign  = ign_q;

  AST_SEQ_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> (err_q inside {ST_SEQ, ST_EXC}));  // R4
  AST_EXC_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
    exc_evt |=> (err_q == ST_EXC));  // R5
  AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (err_q != ST_NULL) && !seq_err && !exc_evt) |=> (err_q == ST_NULL));  // R6
endmodule

// File: rtl/dbgp_seq.sv
module dbgp_seq #(
  parameter int DATA_W  = 32,
  parameter int GAP_MIN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              sdi,
  output logic              sdo,
  output logic              cmd_valid,
  output logic              cmd_mode,
  output logic [DATA_W-1:0] cmd_word,
  input  logic              core_done,
  input  logic              core_exc,
  input  logic              core_wr,
  input  logic [DATA_W-1:0] core_wdata
);
  logic [1:0]        rs_q;
  logic              rst_s_n;
  logic              active, start, done, frame_mode, fwd, busy, ign, tx_msb;
  logic [DATA_W-1:0] frame_word;
  logic [DATA_W+1:0] load_frame;
  logic              cv_q, cm_q;
  logic [DATA_W-1:0] cw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  dbgp_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_s_n), .bit_stb(bit_stb), .sdi(sdi),
    .active(active), .start(start), .done(done),
    .frame_mode(frame_mode), .frame_word(frame_word)
  );

  dbgp_ctl #(.DATA_W(DATA_W), .GAP_MIN(GAP_MIN)) u_ctl (
    .clk(clk), .rst_n(rst_s_n), .start(start), .done(done),
    .core_done(core_done), .core_exc(core_exc), .core_wr(core_wr),
    .core_wdata(core_wdata), .fwd(fwd), .busy(busy), .ign(ign),
    .load_frame(load_frame)
  );

  dbgp_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_s_n), .load(start), .load_frame(load_frame),
    .shift(active && bit_stb), .msb(tx_msb)
  );

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cv_q <= 1'b0;
      cm_q <= 1'b0;
      cw_q <= '0;
    end else begin
      cv_q <= fwd;
      if (fwd) begin
        cm_q <= frame_mode;
        cw_q <= frame_word;
      end
    end
  end

  assign sdo       = active ? tx_msb : busy;
  assign cmd_valid = cv_q;
  assign cmd_mode  = cm_q;
  assign cmd_word  = cw_q;

  AST_FWD_PULSE: assert property (@(posedge clk) disable iff (!rst_s_n)
    cmd_valid |=> !cmd_valid);  // R1
  AST_BUSY_AFTER_FWD: assert property (@(posedge clk) disable iff (!rst_s_n)
    cmd_valid |-> sdo);  // R8
  AST_IGN_NO_FWD: assert property (@(posedge clk) disable iff (!rst_s_n)
    (done && ign) |=> !cmd_valid);  // R7
endmodule

// File: tb/tb_dbgp_seq.sv
module tb_dbgp_seq;
  localparam int MAXT = 32'h7fff_ffff;

  logic        clk = 1'b0;
  logic        rst_n, bit_stb, sdi, sdo;
  logic        cmd_valid, cmd_mode, core_done, core_exc, core_wr;
  logic [31:0] cmd_word, core_wdata;

  int cyc = 0;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // core model configuration for the next forwarded frame
  int c_lat = 1; bit c_wr = 0, c_exc = 0; logic [31:0] c_data = '0;
  // event record for the expectation model
  int done_edge = 0;
  logic [1:0] m_err = 2'b11, m_err_prev = 2'b11; int m_err_t = -1;
  bit m_wr_v = 0, m_wr_pv = 0; logic [31:0] m_wr_d = '0, m_wr_pd = '0; int m_wr_t = -1;
  int t_last_done = -100;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dbgp_seq dut (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .sdi(sdi), .sdo(sdo),
    .cmd_valid(cmd_valid), .cmd_mode(cmd_mode), .cmd_word(cmd_word),
    .core_done(core_done), .core_exc(core_exc), .core_wr(core_wr),
    .core_wdata(core_wdata)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void err_evt(input logic [1:0] code, input int t);
    if (m_err_t < t) m_err_prev = m_err;
    m_err = code;
    m_err_t = t;
  endfunction

  function automatic void wr_evt(input logic [31:0] d, input int t);
    if (m_wr_t < t) begin
      m_wr_pv = m_wr_v;
      m_wr_pd = m_wr_d;
    end
    m_wr_v = 1'b1;
    m_wr_d = d;
    m_wr_t = t;
  endfunction

  // core stand-in
  initial begin
    int cnt; int lat; bit wr, ex; logic [31:0] dd;
    cnt = 0; lat = 1; wr = 0; ex = 0; dd = '0;
    core_done = 0; core_exc = 0; core_wr = 0; core_wdata = '0;
    forever begin
      @(negedge clk);
      core_done = 0; core_exc = 0; core_wr = 0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          core_done = 1; core_exc = ex; core_wr = wr; core_wdata = dd;
          done_edge = cyc + 1;
          if (ex) err_evt(2'b10, cyc + 1);
          if (wr) wr_evt(dd, cyc + 1);
        end
      end
      if (cmd_valid) begin
        cnt = c_lat; lat = c_lat; wr = c_wr; ex = c_exc; dd = c_data;
        done_edge = MAXT;
      end
    end
  end

  // one full frame; called and returning at a falling edge
  task automatic send(input logic md, input logic [31:0] w, input int gap, input int lat,
                      input bit wr, input bit ex);
    logic [33:0] got, expf;
    logic [1:0]  rep, es;
    logic [31:0] ed;
    bit use_v, ign_e, fwd_e;
    logic [31:0] use_d;
    int ts, td;
    c_lat = lat; c_wr = wr; c_exc = ex; c_data = $urandom;
    repeat (gap) @(negedge clk);
    chk(sdo === (done_edge > cyc), (done_edge > cyc) ? "R8 ready withheld" : "R2 ready",
        64'(sdo), 64'(done_edge > cyc));
    sdi = 1'b1; bit_stb = 1'b1; ts = cyc + 1;
    @(posedge clk); #1;
    rep = (m_err_t < ts) ? m_err : m_err_prev;
    use_v = (m_wr_t < ts) ? m_wr_v : m_wr_pv;
    use_d = (m_wr_t < ts) ? m_wr_d : m_wr_pd;
    if (rep != 2'b11) begin
      es = rep; ed = '0; ign_e = 1;
    end else begin
      ign_e = 0;
      if (use_v && (ts - t_last_done >= 4)) begin es = 2'b00; ed = use_d; end
      else begin es = 2'b11; ed = '0; end
    end
    if (m_err_t < ts) m_err = 2'b11;
    m_err_prev = 2'b11;
    if (m_wr_t < ts) m_wr_v = 0;
    m_wr_pv = 0;
    expf = {es, ed};
    for (int i = 1; i <= 34; i++) begin
      @(negedge clk); bit_stb = 1'b0;
      @(negedge clk);
      got[34-i] = sdo;
      sdi = (i == 1) ? md : (i <= 33) ? w[33-i] : 1'($urandom);
      bit_stb = 1'b1;
    end
    @(posedge clk); #1;
    td = cyc;
    t_last_done = td;
    fwd_e = 0;
    if (!ign_e) begin
      if (done_edge > td) err_evt(2'b01, td);
      else begin fwd_e = 1; done_edge = MAXT; end
    end
    @(negedge clk); bit_stb = 1'b0;
    chk(got === expf,
        (es == 2'b00) ? "R9 response" : (es == 2'b01) ? "R4 R6 response" :
        (es == 2'b10) ? "R5 R6 response" : "R3 response", 64'(got), 64'(expf));
    chk(cmd_valid === fwd_e, ign_e ? "R7 not forwarded" : (fwd_e ? "R1 forward" : "R4 discard"),
        64'(cmd_valid), 64'(fwd_e));
    if (fwd_e)
      chk({cmd_mode, cmd_word} === {md, w}, "R1 word", 64'({cmd_mode, cmd_word}), 64'({md, w}));
    chk(sdo === (done_edge > cyc), "R8 after frame", 64'(sdo), 64'(done_edge > cyc));
  endtask

  initial begin
    #(8 * 190000);
    if (!finished) begin
      chk(1'b0, "watchdog", 64'(cyc), 64'd0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int lats[4];
    void'($urandom(32'd20240611));
    lats[0] = 1; lats[1] = 2; lats[2] = 3; lats[3] = 90;
    rst_n = 1'b0; bit_stb = 1'b0; sdi = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(sdo === 1'b0, "R2 reset ready", 64'(sdo), 64'd0);
    chk(cmd_valid === 1'b0, "R1 reset idle", 64'(cmd_valid), 64'd0);
    // R10: zero strobe while idle
    bit_stb = 1'b1; sdi = 1'b0;
    @(negedge clk); bit_stb = 1'b0;
    @(negedge clk);
    chk(sdo === 1'b0, "R10 stray strobe", 64'(sdo), 64'd0);
    // R1 R9: core writes, long gap -> valid data
    send(1'b0, 32'hA5C3_0F11, 2, 1, 1, 0);
    send(1'b1, 32'h1234_5678, 5, 1, 0, 0);
    // R9: short gap (3 edges) -> null, data dropped
    send(1'b0, 32'h0BAD_F00D, 4, 1, 1, 0);
    send(1'b0, 32'hFFFF_0000, 2, 1, 0, 0);
    send(1'b0, 32'h0000_FFFF, 5, 1, 0, 0);
    // R5 R6 R7: exception, reported next, that frame ignored
    send(1'b0, 32'hDEAD_BEEF, 4, 1, 0, 1);
    send(1'b1, 32'hCAFE_0001, 5, 1, 0, 0);
    send(1'b0, 32'h0000_0002, 5, 1, 0, 0);
    // R4 R8: long core op, early start -> discarded, ready withheld
    send(1'b0, 32'h7777_8888, 4, 90, 0, 0);
    send(1'b1, 32'h1111_2222, 0, 1, 0, 0);
    repeat (40) @(negedge clk);
    send(1'b0, 32'h3333_4444, 3, 1, 0, 0);
    send(1'b0, 32'h5555_6666, 5, 1, 0, 0);
    // random mix
    for (int k = 0; k < 60; k++) begin
      send(1'($urandom), $urandom, int'($urandom % 7), lats[$urandom % 4],
           1'($urandom), ($urandom % 5) == 0);
    end
    repeat (120) @(negedge clk);
    send(1'b0, 32'h0, 5, 1, 0, 0);
    send(1'b0, 32'h0, 5, 1, 0, 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule